// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramp

This block produces the 14-bit unsigned amplitude scale that multiplies the samples of a DDS core. In burst transmission it lets the carrier swell and fade over a controlled time, instead of switching on and off abruptly, which keeps the spectrum of short bursts clean. It also returns the scaled sample, so it sits in line between the phase-to-amplitude stage and the DAC.

It has three modes. With the enable input low, the block is transparent: the scale reads full scale and the sample passes through unchanged. With enable high and the auto input low, the scale is taken directly from the low 14 bits of a 16-bit amplitude register. With enable and auto both high, an internal ramp counter sets the scale. The counter moves one step per ramp tick, upward while the keying input is high and downward while it is low. A tick comes every N clocks, where N is an 8-bit rate value. The two top bits of the amplitude register select the step size. The low 14 bits set a ceiling that the ramp never exceeds.

Top module: `osk_ramp`

## Requirements
- R1: While `osk_en` is 0, `scale_out` is 0x3FFF and `sample_out` equals `sample_in`, whatever `osk_auto` is.
- R2: While `osk_en` is 1 and `osk_auto` is 0, `scale_out` equals `amp_reg[13:0]`, and bits 15:14 have no effect on it.
- R3: While `osk_en` is 1, `sample_out` is the signed product of `sample_in` and the unsigned `scale_out`, arithmetically shifted right by 14 (rounding toward minus infinity).
- R4: In auto mode the ramp counter moves once every N clocks, where N is `ramp_rate`; a rate of 0 acts as 1. The first move after the ramp clock restarts lands on the Nth rising edge.
- R5: In auto mode the counter rises while `key_in` is 1 and falls while it is 0.
- R6: `amp_reg[15:14]` selects the step per tick: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R7: In auto mode, `scale_out` never exceeds `amp_reg[13:0]`. A rising step that would pass the ceiling stops at the ceiling. If the ceiling is lowered below the counter, the scale follows it at once.
- R8: A falling step clamps at 0 and never wraps.
- R9: Reset clears the ramp counter to 0, so auto mode starts at scale 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osk_en | input | 1 | Scaling enable; 0 selects bypass |
| osk_auto | input | 1 | 1 selects the internal ramp, 0 selects the register scale |
| key_in | input | 1 | Keying input: 1 ramps up, 0 ramps down |
| ramp_rate | input | 8 | Clocks per ramp tick (0 acts as 1) |
| amp_reg | input | 16 | [15:14] step code, [13:0] manual scale and ramp ceiling |
| sample_in | input | 14 | Signed DDS sample |
| scale_out | output | 14 | Applied unsigned scale factor |
| sample_out | output | 14 | Signed scaled sample |

## Verification
A vector table covers the modes without a ramp: bypass with and without the auto bit, and manual scales using positive, negative, zero and extreme samples. These show that the auto bit is ignored in bypass, that the step bits are ignored in manual mode, and that negative products round down. Directed auto-mode runs then use each step code, slow and zero rate values, a rising ramp that meets the ceiling, a falling ramp that reaches zero, and a ceiling lowered below the counter. Together they separate tick timing from step size and show the clamp at each end.

// File: rtl/osk_ramp.sv
module osk_ramp #(
  parameter int W  = 14,
  parameter int RW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osk_en,
  input  logic                osk_auto,
  input  logic                key_in,
  input  logic [RW-1:0]       ramp_rate,
  input  logic [W+1:0]        amp_reg,
  input  logic signed [W-1:0] sample_in,
  output logic [W-1:0]        scale_out,
  output logic signed [W-1:0] sample_out
);
  localparam logic [W-1:0] FULL = '1;

  logic [RW-1:0] div_q;
  logic [W-1:0]  ramp_q;

  wire           auto_on = osk_en & osk_auto;
  wire [RW-1:0]  period  = (ramp_rate == '0) ? RW'(1) : ramp_rate;
  wire           tick    = auto_on && (div_q >= period - RW'(1));
  wire [W-1:0]   ceil_v  = amp_reg[W-1:0];
  wire [W-1:0]   step    = W'(4'd1 << amp_reg[W+1:W]);
  wire [W:0]     up_sum  = {1'b0, ramp_q} + {1'b0, step};
  wire [W-1:0]   up_nxt  = (up_sum > {1'b0, ceil_v}) ? ceil_v : up_sum[W-1:0];
  wire [W-1:0]   dn_nxt  = (ramp_q > step) ? ramp_q - step : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ramp_q <= '0;
    end else begin
      div_q <= (auto_on && !tick) ? div_q + RW'(1) : '0;
      if (tick) ramp_q <= key_in ? up_nxt : dn_nxt;
    end
  end

  always_comb begin
    if (!osk_en)       scale_out = FULL;
    else if (!osk_auto) scale_out = ceil_v;
    else               scale_out = (ramp_q > ceil_v) ? ceil_v : ramp_q;
  end

  wire signed [2*W:0] prod = sample_in * $signed({1'b0, scale_out});

  assign sample_out = osk_en ? prod[2*W-1:W] : sample_in;
endmodule

// File: rtl/osk_ramp_chk.sv
module osk_ramp_chk #(
  parameter int W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                osk_en,
  input logic                osk_auto,
  input logic                key_in,
  input logic [W+1:0]        amp_reg,
  input logic signed [W-1:0] sample_in,
  input logic [W-1:0]        scale_out,
  input logic signed [W-1:0] sample_out,
  input logic [W-1:0]        ramp_q
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !osk_en |-> (sample_out == sample_in) && (scale_out == {W{1'b1}}));

  assert_manual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (osk_en && !osk_auto) |-> scale_out == amp_reg[W-1:0]);

  assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (osk_en && osk_auto) |-> scale_out <= amp_reg[W-1:0]);

  assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osk_en && osk_auto && key_in && ramp_q < amp_reg[W-1:0]) |=> ramp_q >= $past(ramp_q));

  assert_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osk_en && osk_auto && !key_in) |=> ramp_q <= $past(ramp_q));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (osk_en && osk_auto && key_in && ramp_q < amp_reg[W-1:0]) |=> (ramp_q - $past(ramp_q)) <= W'(8));
endmodule

bind osk_ramp osk_ramp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osk_en(osk_en), .osk_auto(osk_auto),
  .key_in(key_in), .amp_reg(amp_reg), .sample_in(sample_in),
  .scale_out(scale_out), .sample_out(sample_out), .ramp_q(ramp_q)
);

// File: tb/tb_osk_ramp.sv
module tb_osk_ramp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, osk_en = 1'b0, osk_auto = 1'b0, key_in = 1'b0;
  logic [7:0] ramp_rate = 8'd1;
  logic [15:0] amp_reg = 16'd0;
  logic signed [13:0] sample_in = 14'sd0;
  logic [13:0] scale_out;
  logic signed [13:0] sample_out;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osk_ramp dut (.clk(clk), .rst_n(rst_n), .osk_en(osk_en), .osk_auto(osk_auto),
    .key_in(key_in), .ramp_rate(ramp_rate), .amp_reg(amp_reg),
    .sample_in(sample_in), .scale_out(scale_out), .sample_out(sample_out));

  typedef struct packed {
    logic en; logic au; logic [15:0] amp;
    logic signed [13:0] smp; logic [13:0] xs; logic signed [13:0] xo;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 16'h0000, -14'sd1234, 14'h3FFF, -14'sd1234},
    '{1'b0, 1'b1, 16'h1234,  14'sd777,  14'h3FFF,  14'sd777},
    '{1'b1, 1'b0, 16'h2000,  14'sd1000, 14'h2000,  14'sd500},
    '{1'b1, 1'b0, 16'h2000, -14'sd1000, 14'h2000, -14'sd500},
    '{1'b1, 1'b0, 16'h0000,  14'sd8191, 14'h0000,  14'sd0},
    '{1'b1, 1'b0, 16'hC123,  14'sd4096, 14'h0123,  14'sd72},
    '{1'b1, 1'b0, 16'h3FFF,  14'sd8191, 14'h3FFF,  14'sd8190},
    '{1'b1, 1'b0, 16'h3FFF, -14'sd8192, 14'h3FFF, -14'sd8192}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset clears the ramp; auto mode reads 0
    osk_en = 1'b1; osk_auto = 1'b1; key_in = 1'b1; amp_reg = 16'h3FFF;
    wait_edges(3);
    chk("R9", scale_out, 0);
    rst_n = 1'b1;
    osk_en = 1'b0; osk_auto = 1'b0;

    // R1 R2 R3: table of non-ramp vectors
    for (int i = 0; i < 8; i++) begin
      osk_en = VEC[i].en; osk_auto = VEC[i].au; amp_reg = VEC[i].amp;
      sample_in = VEC[i].smp;
      #1;
      chk(VEC[i].en ? "R2" : "R1", scale_out, VEC[i].xs);
      chk("R3", sample_out, VEC[i].xo);
    end

    // R4 R5 R7: rate 3, step 1, ceiling 10
    @(negedge clk);
    osk_en = 1'b1; osk_auto = 1'b1; key_in = 1'b1; ramp_rate = 8'd3;
    amp_reg = {2'b00, 14'd10}; sample_in = 14'sd4096;
    wait_edges(2);
    chk("R4", scale_out, 0);
    wait_edges(1);
    chk("R4", scale_out, 1);
    chk("R3", sample_out, 0);
    wait_edges(27);
    chk("R5", scale_out, 10);
    wait_edges(9);
    chk("R7", scale_out, 10);

    // R6 R7: step 8, rate 0 acts as 1, ceiling 20
    ramp_rate = 8'd0; amp_reg = {2'b11, 14'd20};
    wait_edges(1);
    chk("R6", scale_out, 18);
    wait_edges(1);
    chk("R7", scale_out, 20);

    // R8: falling by 8 from 20 clamps at 0
    key_in = 1'b0;
    wait_edges(2);
    chk("R5", scale_out, 4);
    wait_edges(1);
    chk("R8", scale_out, 0);
    wait_edges(2);
    chk("R8", scale_out, 0);

    // R6: step codes 01 and 10
    key_in = 1'b1; ramp_rate = 8'd1; amp_reg = {2'b01, 14'h3FFF};
    wait_edges(1);
    chk("R6", scale_out, 2);
    amp_reg = {2'b10, 14'h3FFF};
    wait_edges(1);
    chk("R6", scale_out, 6);
    chk("R3", sample_out, 1);

    // R4: rate 5 moves on the 5th edge, not the 4th
    ramp_rate = 8'd5;
    wait_edges(4);
    chk("R4", scale_out, 6);
    wait_edges(1);
    chk("R4", scale_out, 10);

    // R7: lowered ceiling takes effect at once
    amp_reg = {2'b00, 14'd5};
    #1;
    chk("R7", scale_out, 5);

    // R2: manual mode in front of a held ramp
    osk_auto = 1'b0; amp_reg = 16'h8100;
    #1;
    chk("R2", scale_out, 14'h0100);

    wait_edges(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule